// File: doc/BRIEF.md
# Operand Addressing-Mode Decoder

This block sits in the decode stage of a 16-bit processor. It takes a two-operand instruction word and works out how each operand is reached. The source side has a 2-bit mode field and the destination side has a 1-bit mode field. Each mode field is read together with the register number it names. A naming register can turn a mode code into symbolic, absolute or immediate addressing, or into a hardware constant that needs no memory operand at all.

For each operand the decoder reports the following:
- the resolved mode
- whether an extension word follows the instruction
- the effective address, formed from the register value supplied by the register file and the matching extension word
- any literal value, either a generated constant or an immediate
- how far the source register must step after the access.

It also reports the instruction length in words and whether the operation is on bytes. The caller supplies the instruction's own byte address and up to two words that follow it. All outputs are registered and appear one cycle after a valid input.

Top module: `opmd_dec`

## Requirements
- R1: Instruction fields are: source register bits [11:8], destination mode bit 7, byte flag bit 6, source mode bits [5:4], destination register bits [3:0]. For a source register other than 0, 2 or 3, source mode 00/01/10/11 gives register (code 0), indexed (code 1), indirect (code 4) and autoincrement (code 5). Indexed sets `o_src_ext`, and its address is the register value plus the extension word. Register mode reports address 0.
- R2: Source register 0 with mode 01 is symbolic (code 2). It needs an extension word, and its address is that extension word's own byte address plus the word's value.
- R3: Source register 2 with mode 01 is absolute (code 3). It needs an extension word, and the address is the extension word itself.
- R4: Source register 0 with mode 11 is immediate (code 6). It needs an extension word, the literal is that word, `o_src_lit_vld` is 1, and the address is the extension word's byte address.
- R5: These combinations give a constant (code 7) with no extension word and `o_src_lit_vld` set: register 2 with mode 10 gives 4, register 2 with mode 11 gives 8, and register 3 with modes 00/01/10/11 gives 0, 1, 2 and 0xFFFF. Register 2 with mode 00 remains register mode.
- R6: Autoincrement reports step 1 for a byte operation and 2 for a word operation, and step 0 for every other mode. Indirect and autoincrement both use the register value from before the step as the address.
- R7: Destination mode 0 is register (code 0) with no extension word. Destination mode 1 needs an extension word. With mode 1, register 0 gives symbolic (code 2), register 2 gives absolute (code 3), and any other register gives indexed (code 1), with addresses formed as for the source.
- R8: Extension words are ordered with the source first. The destination uses the first following word when the source needs none, and the second otherwise. Its symbolic base is the byte address of the word it uses.
- R9: `o_len` is 1 plus one for each operand that needs an extension word, so 1, 2 or 3.
- R10: `o_byte` equals instruction bit 6 (1 = byte).
- R11: Outputs update one clock edge after the input is sampled. `o_vld` follows `i_vld` with that delay. An active-low reset clears `o_vld` and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_vld | input | 1 | Instruction presented this cycle |
| i_instr | input | 16 | Two-operand instruction word |
| i_src_val | input | 16 | Current value of the source register |
| i_dst_val | input | 16 | Current value of the destination register |
| i_pc | input | 16 | Byte address of the instruction word |
| i_ext0 | input | 16 | First word after the instruction |
| i_ext1 | input | 16 | Second word after the instruction |
| o_vld | output | 1 | Decoded result valid |
| o_src_mode | output | 3 | Source mode code |
| o_src_ext | output | 1 | Source needs an extension word |
| o_src_ea | output | 16 | Source effective address |
| o_src_lit | output | 16 | Constant or immediate value |
| o_src_lit_vld | output | 1 | Source operand is a literal |
| o_src_step | output | 2 | Post-access register step |
| o_dst_mode | output | 3 | Destination mode code |
| o_dst_ext | output | 1 | Destination needs an extension word |
| o_dst_ea | output | 16 | Destination effective address |
| o_len | output | 2 | Instruction length in words |
| o_byte | output | 1 | Byte operation flag |

## Verification
The same general-purpose register is driven through all four source mode codes. Registers 0, 2 and 3 are then driven with the same codes, which shows that the register number, not the code alone, picks symbolic, absolute, immediate or constant. Destination cases are paired with a source that needs no extension word and with a source that needs one. This pairing separates correct word ordering and symbolic base from a destination that always takes the first word. The byte flag is toggled on an autoincrement source so that the step of 1 is told apart from the step of 2. Back-to-back valid cycles follow idle cycles, which shows that the valid bit tracks each input and does not linger.

// File: rtl/opmd_pkg.sv
package opmd_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned STEP_W  = 2;
  localparam int unsigned LEN_W   = 2;
  // instruction field positions (neighbouring decode relies on these)
  localparam int unsigned SREG_LSB = 8;
  localparam int unsigned DMODE_BIT = 7;
  localparam int unsigned BYTE_BIT  = 6;
  localparam int unsigned SMODE_LSB = 4;
  localparam int unsigned DREG_LSB  = 0;
  // special register numbers
  localparam logic [3:0] RN_PC = 4'd0;
  localparam logic [3:0] RN_SR = 4'd2;
  localparam logic [3:0] RN_CG = 4'd3;

  typedef enum logic [2:0] {
    AM_REG   = 3'd0,
    AM_IDX   = 3'd1,
    AM_SYM   = 3'd2,
    AM_ABS   = 3'd3,
    AM_IND   = 3'd4,
    AM_AINC  = 3'd5,
    AM_IMM   = 3'd6,
    AM_CONST = 3'd7
  } amode_e;

  function automatic amode_e src_mode_of(logic [1:0] code, logic [3:0] rn);
    amode_e m;
    if (rn == RN_CG) m = AM_CONST;
    else if (rn == RN_SR && code[1]) m = AM_CONST;
    else begin
      unique case (code)
        2'b00: m = AM_REG;
        2'b01: m = (rn == RN_PC) ? AM_SYM : (rn == RN_SR) ? AM_ABS : AM_IDX;
        2'b10: m = AM_IND;
        default: m = (rn == RN_PC) ? AM_IMM : AM_AINC;
      endcase
    end
    return m;
  endfunction

  function automatic amode_e dst_mode_of(logic code, logic [3:0] rn);
    if (!code) return AM_REG;
    if (rn == RN_PC) return AM_SYM;
    if (rn == RN_SR) return AM_ABS;
    return AM_IDX;
  endfunction

  function automatic logic takes_ext(amode_e m);
    return (m == AM_IDX) || (m == AM_SYM) || (m == AM_ABS) || (m == AM_IMM);
  endfunction

  function automatic logic [WORD_W-1:0] const_of(logic [1:0] code, logic [3:0] rn);
    logic [WORD_W-1:0] v;
    if (rn == RN_SR) v = code[0] ? WORD_W'(8) : WORD_W'(4);
    else begin
      unique case (code)
        2'b00: v = '0;
        2'b01: v = WORD_W'(1);
        2'b10: v = WORD_W'(2);
        default: v = '1;
      endcase
    end
    return v;
  endfunction

  function automatic logic [STEP_W-1:0] step_of(amode_e m, logic is_byte);
    if (m != AM_AINC) return '0;
    return is_byte ? STEP_W'(1) : STEP_W'(2);
  endfunction
endpackage

// File: rtl/opmd_src.sv
module opmd_src
  import opmd_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic [1:0]        mode_code,
  input  logic [3:0]        rn,
  input  logic              is_byte,
  input  logic [DW-1:0]     reg_val,
  input  logic [DW-1:0]     pc,
  input  logic [DW-1:0]     ext_word,
  output amode_e            mode,
  output logic              need_ext,
  output logic [DW-1:0]     ea,
  output logic [DW-1:0]     lit,
  output logic              lit_vld,
  output logic [STEP_W-1:0] step
);
  localparam logic [DW-1:0] WORD_BYTES = DW'(2);

  logic [DW-1:0] ext_addr;
  assign ext_addr = pc + WORD_BYTES;

  always_comb begin
    mode     = src_mode_of(mode_code, rn);
    need_ext = takes_ext(mode);
    step     = step_of(mode, is_byte);
    lit      = '0;
    lit_vld  = 1'b0;
    ea       = '0;
    unique case (mode)
      AM_IDX:          ea = reg_val + ext_word;
      AM_SYM:          ea = ext_addr + ext_word;
      AM_ABS:          ea = ext_word;
      AM_IND, AM_AINC: ea = reg_val;
      AM_IMM: begin
        ea      = ext_addr;
        lit     = ext_word;
        lit_vld = 1'b1;
      end
      AM_CONST: begin
        lit     = DW'(const_of(mode_code, rn));
        lit_vld = 1'b1;
      end
      default: ea = '0;
    endcase
  end
endmodule

// File: rtl/opmd_dst.sv
module opmd_dst
  import opmd_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          mode_code,
  input  logic [3:0]    rn,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] pc,
  input  logic          src_uses_ext,
  input  logic [DW-1:0] ext0,
  input  logic [DW-1:0] ext1,
  output amode_e        mode,
  output logic          need_ext,
  output logic          use_second,
  output logic [DW-1:0] ea
);
  localparam logic [DW-1:0] ONE_WORD = DW'(2);
  localparam logic [DW-1:0] TWO_WORD = DW'(4);

  logic [DW-1:0] x;
  logic [DW-1:0] ext_addr;

  assign use_second = src_uses_ext;
  assign x          = use_second ? ext1 : ext0;
  assign ext_addr   = pc + (use_second ? TWO_WORD : ONE_WORD);

  always_comb begin
    mode     = dst_mode_of(mode_code, rn);
    need_ext = takes_ext(mode);
    unique case (mode)
      AM_IDX:  ea = reg_val + x;
      AM_SYM:  ea = ext_addr + x;
      AM_ABS:  ea = x;
      default: ea = '0;
    endcase
  end
endmodule

// File: rtl/opmd_dec.sv
module opmd_dec
  import opmd_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_vld,
  input  logic [15:0]       i_instr,
  input  logic [DW-1:0]     i_src_val,
  input  logic [DW-1:0]     i_dst_val,
  input  logic [DW-1:0]     i_pc,
  input  logic [DW-1:0]     i_ext0,
  input  logic [DW-1:0]     i_ext1,
  output logic              o_vld,
  output logic [2:0]        o_src_mode,
  output logic              o_src_ext,
  output logic [DW-1:0]     o_src_ea,
  output logic [DW-1:0]     o_src_lit,
  output logic              o_src_lit_vld,
  output logic [STEP_W-1:0] o_src_step,
  output logic [2:0]        o_dst_mode,
  output logic              o_dst_ext,
  output logic [DW-1:0]     o_dst_ea,
  output logic [LEN_W-1:0]  o_len,
  output logic              o_byte
);
  logic [1:0] smode_f;
  logic [3:0] sreg_f;
  logic [3:0] dreg_f;
  logic       dmode_f;
  logic       byte_f;

  assign smode_f = i_instr[SMODE_LSB +: 2];
  assign sreg_f  = i_instr[SREG_LSB +: 4];
  assign dreg_f  = i_instr[DREG_LSB +: 4];
  assign dmode_f = i_instr[DMODE_BIT];
  assign byte_f  = i_instr[BYTE_BIT];

  amode_e              s_mode, d_mode;
  logic                s_ext, d_ext, d_second, s_lit_vld;
  logic [DW-1:0]       s_ea, s_lit, d_ea;
  logic [STEP_W-1:0]   s_step;
  logic [LEN_W-1:0]    len_c;

  opmd_src #(.DW(DW)) u_src (
    .mode_code(smode_f), .rn(sreg_f), .is_byte(byte_f),
    .reg_val(i_src_val), .pc(i_pc), .ext_word(i_ext0),
    .mode(s_mode), .need_ext(s_ext), .ea(s_ea),
    .lit(s_lit), .lit_vld(s_lit_vld), .step(s_step)
  );

  opmd_dst #(.DW(DW)) u_dst (
    .mode_code(dmode_f), .rn(dreg_f), .reg_val(i_dst_val), .pc(i_pc),
    .src_uses_ext(s_ext), .ext0(i_ext0), .ext1(i_ext1),
    .mode(d_mode), .need_ext(d_ext), .use_second(d_second), .ea(d_ea)
  );

  assign len_c = LEN_W'(1) + LEN_W'(s_ext) + LEN_W'(d_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld         <= 1'b0;
      o_src_mode    <= '0;
      o_src_ext     <= 1'b0;
      o_src_ea      <= '0;
      o_src_lit     <= '0;
      o_src_lit_vld <= 1'b0;
      o_src_step    <= '0;
      o_dst_mode    <= '0;
      o_dst_ext     <= 1'b0;
      o_dst_ea      <= '0;
      o_len         <= '0;
      o_byte        <= 1'b0;
    end else begin
      o_vld <= i_vld;
      if (i_vld) begin
        o_src_mode    <= s_mode;
        o_src_ext     <= s_ext;
        o_src_ea      <= s_ea;
        o_src_lit     <= s_lit;
        o_src_lit_vld <= s_lit_vld;
        o_src_step    <= s_step;
        o_dst_mode    <= d_mode;
        o_dst_ext     <= d_ext;
        o_dst_ea      <= d_ea;
        o_len         <= len_c;
        o_byte        <= byte_f;
      end
    end
  end
endmodule

// File: rtl/opmd_chk.sv
module opmd_chk
  import opmd_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_vld,
  input logic [15:0]       i_instr,
  input logic [DW-1:0]     i_ext0,
  input logic              o_vld,
  input logic [2:0]        o_src_mode,
  input logic              o_src_ext,
  input logic [DW-1:0]     o_src_lit,
  input logic              o_src_lit_vld,
  input logic [STEP_W-1:0] o_src_step,
  input logic              o_dst_ext,
  input logic [LEN_W-1:0]  o_len,
  input logic              o_byte
);
  p_vld_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    i_vld |=> o_vld);
  p_vld_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !i_vld |=> !o_vld);
  p_const_no_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && o_src_mode == 3'd7) |-> (!o_src_ext && o_src_lit_vld));
  p_imm_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && o_src_mode == 3'd6) |-> (o_src_ext && o_src_lit == $past(i_ext0)));
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && o_src_step != '0) |->
      (o_src_mode == 3'd5 && o_src_step == ($past(i_instr[BYTE_BIT]) ? 2'd1 : 2'd2)));
  p_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |-> (o_byte == $past(i_instr[BYTE_BIT])));
  p_dst_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |-> (o_dst_ext == $past(i_instr[DMODE_BIT])));
  p_len_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |-> (o_len >= 2'd1 && o_len <= 2'd3));
endmodule

bind opmd_dec opmd_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_instr(i_instr), .i_ext0(i_ext0),
  .o_vld(o_vld), .o_src_mode(o_src_mode), .o_src_ext(o_src_ext),
  .o_src_lit(o_src_lit), .o_src_lit_vld(o_src_lit_vld), .o_src_step(o_src_step),
  .o_dst_ext(o_dst_ext), .o_len(o_len), .o_byte(o_byte)
);

// File: tb/opmd_dec_tb.sv
module opmd_dec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        i_vld = 1'b0;
  logic [15:0] i_instr = '0, i_src_val = '0, i_dst_val = '0, i_pc = '0, i_ext0 = '0, i_ext1 = '0;
  logic        o_vld, o_src_ext, o_src_lit_vld, o_dst_ext, o_byte;
  logic [2:0]  o_src_mode, o_dst_mode;
  logic [15:0] o_src_ea, o_src_lit, o_dst_ea;
  logic [1:0]  o_src_step, o_len;

  opmd_dec u_dut (.*);

  typedef struct {
    logic [2:0] sm; logic sx; logic [15:0] sea; logic [15:0] lit; logic lv;
    logic [1:0] stp; logic [2:0] dm; logic dx; logic [15:0] dea;
    logic [1:0] len; logic by; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [3:0] sr, logic ad, logic by, logic [1:0] as_c, logic [3:0] dr);
    return {4'h4, sr, ad, by, as_c, dr};
  endfunction

  task automatic drive(logic [3:0] sr, logic ad, logic by, logic [1:0] as_c, logic [3:0] dr,
                       logic [15:0] sv, logic [15:0] dv, logic [15:0] pc,
                       logic [15:0] e0, logic [15:0] e1, string tag);
    exp_t e;
    logic [15:0] dx_word, dx_addr;
    e.tag = tag; e.by = by; e.sea = 0; e.lit = 0; e.lv = 0; e.stp = 0; e.sx = 0;
    // source model: check special registers first
    if (sr == 4'd3) begin
      e.sm = 7; e.lv = 1;
      e.lit = (as_c == 0) ? 16'h0 : (as_c == 1) ? 16'h1 : (as_c == 2) ? 16'h2 : 16'hFFFF;
    end else if (sr == 4'd2 && as_c >= 2) begin
      e.sm = 7; e.lv = 1; e.lit = (as_c == 2) ? 16'd4 : 16'd8;
    end else if (as_c == 0) e.sm = 0;
    else if (as_c == 1) begin
      e.sx = 1;
      if (sr == 0)      begin e.sm = 2; e.sea = pc + 16'd2 + e0; end
      else if (sr == 2) begin e.sm = 3; e.sea = e0; end
      else              begin e.sm = 1; e.sea = sv + e0; end
    end else if (as_c == 2) begin e.sm = 4; e.sea = sv; end
    else if (sr == 0) begin e.sm = 6; e.sx = 1; e.sea = pc + 16'd2; e.lit = e0; e.lv = 1; end
    else begin e.sm = 5; e.sea = sv; e.stp = by ? 2'd1 : 2'd2; end
    // destination model
    dx_word = e.sx ? e1 : e0;
    dx_addr = e.sx ? pc + 16'd4 : pc + 16'd2;
    e.dx = ad; e.dea = 0;
    if (!ad) e.dm = 0;
    else if (dr == 0) begin e.dm = 2; e.dea = dx_addr + dx_word; end
    else if (dr == 2) begin e.dm = 3; e.dea = dx_word; end
    else              begin e.dm = 1; e.dea = dv + dx_word; end
    e.len = 2'(1 + e.sx + e.dx);
    q.push_back(e);
    @(negedge clk);
    i_vld = 1; i_instr = mk(sr, ad, by, as_c, dr);
    i_src_val = sv; i_dst_val = dv; i_pc = pc; i_ext0 = e0; i_ext1 = e1;
  endtask

  task automatic idle();
    @(negedge clk);
    i_vld = 0; i_instr = 16'hFFFF; i_ext0 = 16'hDEAD;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && o_vld) begin
        if (q.size() == 0) chk("R11", "unexpected o_vld", 16'(o_vld), 16'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, "src_mode", 16'(o_src_mode), 16'(e.sm));
          chk(e.tag, "src_ext", 16'(o_src_ext), 16'(e.sx));
          chk(e.tag, "src_ea", o_src_ea, e.sea);
          chk(e.tag, "src_lit", o_src_lit, e.lit);
          chk(e.tag, "src_lit_vld", 16'(o_src_lit_vld), 16'(e.lv));
          chk(e.tag, "src_step", 16'(o_src_step), 16'(e.stp));
          chk(e.tag, "dst_mode", 16'(o_dst_mode), 16'(e.dm));
          chk(e.tag, "dst_ext", 16'(o_dst_ext), 16'(e.dx));
          chk(e.tag, "dst_ea", o_dst_ea, e.dea);
          chk("R9", "len", 16'(o_len), 16'(e.len));
          chk("R10", "byte", 16'(o_byte), 16'(e.by));
        end
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    i_instr = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R11", "reset o_vld", 16'(o_vld), 16'd0);
    chk("R11", "reset src_ea", o_src_ea, 16'd0);
    chk("R11", "reset len", 16'(o_len), 16'd0);
    rst_n = 1;
    idle(); idle();
    chk("R11", "idle o_vld", 16'(o_vld), 16'd0);
    // R1 general register, all four source codes
    drive(4'd5, 0, 0, 2'b00, 4'd6, 16'h1234, 16'h0, 16'h0400, 16'h0020, 16'h0, "R1");
    drive(4'd5, 0, 0, 2'b01, 4'd6, 16'h1234, 16'h0, 16'h0400, 16'h0020, 16'h0, "R1");
    drive(4'd6, 0, 0, 2'b10, 4'd6, 16'h2000, 16'h0, 16'h0400, 16'h0, 16'h0, "R1");
    drive(4'd7, 0, 0, 2'b11, 4'd8, 16'h3000, 16'h0, 16'h0400, 16'h0, 16'h0, "R6");
    drive(4'd7, 0, 1, 2'b11, 4'd8, 16'h3001, 16'h0, 16'h0400, 16'h0, 16'h0, "R6");
    idle();
    // R2 symbolic, R3 absolute, R4 immediate
    drive(4'd0, 0, 0, 2'b01, 4'd4, 16'h0, 16'h0, 16'h1000, 16'h0010, 16'h0, "R2");
    drive(4'd2, 0, 0, 2'b01, 4'd4, 16'h0, 16'h0, 16'h1000, 16'h0200, 16'h0, "R3");
    drive(4'd0, 0, 1, 2'b11, 4'd4, 16'h0, 16'h0, 16'h1000, 16'hBEEF, 16'h0, "R4");
    drive(4'd0, 0, 0, 2'b10, 4'd4, 16'h1010, 16'h0, 16'h1000, 16'h0, 16'h0, "R1");
    // R5 constants
    for (int k = 0; k < 4; k++)
      drive(4'd3, 0, 0, 2'(k), 4'd4, 16'h5555, 16'h0, 16'h2000, 16'h7777, 16'h0, "R5");
    drive(4'd2, 0, 0, 2'b10, 4'd4, 16'h0, 16'h0, 16'h2000, 16'h7777, 16'h0, "R5");
    drive(4'd2, 0, 0, 2'b11, 4'd4, 16'h0, 16'h0, 16'h2000, 16'h7777, 16'h0, "R5");
    drive(4'd2, 0, 0, 2'b00, 4'd4, 16'h0, 16'h0, 16'h2000, 16'h7777, 16'h0, "R5");
    idle();
    // R7 destination modes with a register source
    drive(4'd5, 1, 0, 2'b00, 4'd0, 16'h0, 16'h0, 16'h3000, 16'h0040, 16'h9999, "R7");
    drive(4'd5, 1, 0, 2'b00, 4'd2, 16'h0, 16'h0, 16'h3000, 16'h0300, 16'h9999, "R7");
    drive(4'd5, 1, 0, 2'b00, 4'd9, 16'h0, 16'h0800, 16'h3000, 16'h0006, 16'h9999, "R7");
    drive(4'd5, 1, 0, 2'b10, 4'd3, 16'h0, 16'h0100, 16'h3000, 16'h0002, 16'h9999, "R7");
    // R8 ordering: source takes ext0, destination takes ext1
    drive(4'd5, 1, 0, 2'b01, 4'd0, 16'h0100, 16'h0, 16'h3000, 16'h0004, 16'h0050, "R8");
    drive(4'd0, 1, 0, 2'b11, 4'd9, 16'h0, 16'h0A00, 16'h3000, 16'h1234, 16'h000A, "R8");
    drive(4'd2, 1, 1, 2'b01, 4'd2, 16'h0, 16'h0, 16'h3000, 16'h0400, 16'h0402, "R8");
    drive(4'd3, 1, 0, 2'b11, 4'd0, 16'h0, 16'h0, 16'h3000, 16'h0010, 16'h0020, "R8");
    idle(); idle(); idle();
    chk("R11", "o_vld after idle", 16'(o_vld), 16'd0);
    chk("R11", "queue drained", 16'(q.size()), 16'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule